// File: doc/BRIEF.md
# LIN Transceiver Mode and Dominant-Guard Controller

This block is the digital control core of a LIN physical-layer transceiver. Three inputs pick its operating mode: a 2-bit system mode code, a standby-control bit for this transceiver, and a battery undervoltage flag. The mode is Active, Lowpower or Off. In Active mode the block passes the transmit data input to the bus-drive output. It also returns the synchronized bus level on the receive output. In every other mode the bus is left recessive.

A guard timer stops a stuck-low transmit input from holding the bus dominant forever. After a configurable number of consecutive dominant clocks, the transmitter is cut off. Only a return of the transmit input to recessive re-arms it. In Lowpower mode a wake filter watches the bus. A dominant level held for a minimum number of clocks produces a one-cycle wake pulse and sets a sticky flag, which stays set until it is cleared from outside. Shorter dominant pulses are rejected. All time limits are counted in clock cycles.

Top module: `lin_phy_ctrl`

## Requirements
- R1: `mode_out` is registered and takes effect one clock after the inputs are sampled. It reads 2'b10 (Active) when `sys_mode` is 2'b10 or 2'b11, `stby_ctl` is 0 and `uv_flag` is 0.
- R2: When `stby_ctl` is 1, `mode_out` reads 2'b01 (Lowpower), whatever `sys_mode` and `uv_flag` are.
- R3: When `stby_ctl` is 0 and either `sys_mode` is 2'b00/2'b01 or `uv_flag` is 1, `mode_out` reads 2'b00 (Off).
- R4: In Active mode `rxd_out` equals `bus_in` delayed by RX_SYNC clocks (bus dominant = 0, recessive = 1). In other modes `rxd_out` is 1.
- R5: `bus_tx` (0 = drive dominant, 1 = recessive) equals `txd_in` in Active mode while the guard is not tripped. In Lowpower and Off modes it is 1.
- R6: After DOM_TIMEOUT consecutive clock edges that sample `txd_in` low, `bus_tx` is forced to 1 and `tx_blocked` reads 1.
- R7: Once tripped, the guard stays tripped while `txd_in` stays low. It is cleared only when a clock edge samples `txd_in` high. The consecutive-low count then starts again from zero.
- R8: During and right after reset, `mode_out` is 2'b00, `bus_tx` and `rxd_out` are 1, and `tx_blocked`, `wake_pulse` and `wake_flag` are 0.
- R9: In Lowpower mode, a synchronized bus level that stays dominant for WAKE_MIN consecutive clocks raises `wake_pulse` for exactly one cycle. One dominant period gives one pulse. Shorter dominant periods give none.
- R10: `wake_flag` rises together with `wake_pulse` and stays 1 until `wake_clr` is sampled high. A detection in the same cycle as `wake_clr` leaves the flag at 1.
- R11: In Active and Off modes, no bus activity produces `wake_pulse` or `wake_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 2 | System mode code |
| stby_ctl | input | 1 | Transceiver standby control, 1 = Lowpower |
| uv_flag | input | 1 | Battery undervoltage, 1 = below recovery threshold |
| txd_in | input | 1 | Transmit data from the protocol controller |
| bus_in | input | 1 | Raw bus level, 0 = dominant |
| wake_clr | input | 1 | Clears the sticky wake flag |
| bus_tx | output | 1 | Bus drive, 0 = dominant |
| rxd_out | output | 1 | Received data to the protocol controller |
| mode_out | output | 2 | Current mode: 00 Off, 01 Lowpower, 10 Active |
| tx_blocked | output | 1 | Dominant guard tripped |
| wake_pulse | output | 1 | One-cycle bus wake detection |
| wake_flag | output | 1 | Sticky wake indication |

## Verification
Two pairs of functions can meet in the same clock cycle.

The first pair is wake detection and the external flag clear. The bench holds the bus dominant and raises `wake_clr` for exactly the edge at which the filter reaches WAKE_MIN. It then expects `wake_pulse` and `wake_flag` both high, and expects a later clear on its own to drop the flag.

The second pair is the guard trip and a transmit release. The bench holds the transmit input low past the timeout and then releases it. It checks that the guard count restarts from zero on the next low period.

// File: rtl/lin_phy_pkg.sv
package lin_phy_pkg;
   typedef enum logic [1:0] {
      LM_OFF    = 2'b00,
      LM_LOWPWR = 2'b01,
      LM_ACTIVE = 2'b10
   } lin_mode_e;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else if (STAGES == 1) sh_q <= d_in;
            else sh_q <= {sh_q[STAGES-2:0], d_in};
         end
         assign d_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lin_mode_sel.sv
module lin_mode_sel
   import lin_phy_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sys_mode,
   input  logic       stby_ctl,
   input  logic       uv_flag,
   output lin_mode_e  mode_q
);
   lin_mode_e mode_d;

   always_comb begin
      if (stby_ctl) mode_d = LM_LOWPWR;
      else if ((sys_mode == 2'b10 || sys_mode == 2'b11) && !uv_flag) mode_d = LM_ACTIVE;
      else mode_d = LM_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= LM_OFF;
      else mode_q <= mode_d;
   end

   assert_active_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && mode_q == LM_ACTIVE) |-> ($past(sys_mode[1]) && !$past(stby_ctl) && !$past(uv_flag)));
   assert_stby_lowpwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stby_ctl)) |-> mode_q == LM_LOWPWR);
   assert_off_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(stby_ctl) && ($past(uv_flag) || !$past(sys_mode[1]))) |-> mode_q == LM_OFF);
endmodule

// File: rtl/lin_dom_guard.sv
module lin_dom_guard #(
   parameter int DOM_TIMEOUT = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_in,
   output logic blocked_q
);
   localparam int CNT_W = $clog2(DOM_TIMEOUT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DOM_TIMEOUT - 1);

   initial begin
      if (DOM_TIMEOUT < 2) $fatal(1, "DOM_TIMEOUT must be at least 2");
   end

   logic [CNT_W-1:0] low_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         blocked_q <= 1'b0;
      end else if (txd_in) begin
         low_cnt_q <= '0;
         blocked_q <= 1'b0;
      end else begin
         if (low_cnt_q == LAST) blocked_q <= 1'b1;
         if (low_cnt_q < LAST) low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   assert_hold_while_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(blocked_q) && !$past(txd_in)) |-> blocked_q);
   assert_rearm_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(txd_in)) |-> (!blocked_q && low_cnt_q == '0));
   assert_trip_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blocked_q) |-> ($past(low_cnt_q) == LAST && !$past(txd_in)));
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
   parameter int WAKE_MIN = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lowpwr,
   input  logic bus_s,
   input  logic wake_clr,
   output logic pulse_q,
   output logic flag_q
);
   localparam int CNT_W = $clog2(WAKE_MIN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_MIN - 1);

   initial begin
      if (WAKE_MIN < 2) $fatal(1, "WAKE_MIN must be at least 2");
   end

   logic [CNT_W-1:0] dom_cnt_q;
   logic             fired_q;
   logic             hit;

   assign hit = lowpwr && !bus_s && !fired_q && dom_cnt_q == LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_cnt_q <= '0;
         fired_q   <= 1'b0;
         pulse_q   <= 1'b0;
         flag_q    <= 1'b0;
      end else begin
         pulse_q <= hit;
         flag_q  <= hit | (flag_q & ~wake_clr);
         if (!lowpwr || bus_s) begin
            dom_cnt_q <= '0;
            fired_q   <= 1'b0;
         end else begin
            if (hit) fired_q <= 1'b1;
            if (dom_cnt_q < LAST) dom_cnt_q <= dom_cnt_q + 1'b1;
         end
      end
   end

   assert_pulse_in_lowpwr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> ($past(rst_n) && $past(lowpwr)));
   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   assert_flag_with_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> flag_q);
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(flag_q) && !$past(wake_clr)) |-> flag_q);
endmodule

// File: rtl/lin_phy_ctrl.sv
module lin_phy_ctrl
   import lin_phy_pkg::*;
#(
   parameter int DOM_TIMEOUT = 40,
   parameter int WAKE_MIN    = 12,
   parameter int RX_SYNC     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sys_mode,
   input  logic       stby_ctl,
   input  logic       uv_flag,
   input  logic       txd_in,
   input  logic       bus_in,
   input  logic       wake_clr,
   output logic       bus_tx,
   output logic       rxd_out,
   output logic [1:0] mode_out,
   output logic       tx_blocked,
   output logic       wake_pulse,
   output logic       wake_flag
);
   initial begin
      if (RX_SYNC < 0 || RX_SYNC > 4) $fatal(1, "RX_SYNC must be 0..4");
   end

   lin_mode_e mode_q;
   logic      bus_s;
   logic      is_active;

   lin_mode_sel u_mode (
      .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode),
      .stby_ctl(stby_ctl), .uv_flag(uv_flag), .mode_q(mode_q)
   );

   lin_rx_sync #(.STAGES(RX_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(bus_in), .d_out(bus_s)
   );

   lin_dom_guard #(.DOM_TIMEOUT(DOM_TIMEOUT)) u_guard (
      .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .blocked_q(tx_blocked)
   );

   lin_wake_filter #(.WAKE_MIN(WAKE_MIN)) u_wake (
      .clk(clk), .rst_n(rst_n), .lowpwr(mode_q == LM_LOWPWR),
      .bus_s(bus_s), .wake_clr(wake_clr),
      .pulse_q(wake_pulse), .flag_q(wake_flag)
   );

   assign is_active = (mode_q == LM_ACTIVE);
   assign mode_out  = mode_q;
   assign bus_tx    = (is_active && !tx_blocked) ? txd_in : 1'b1;
   assign rxd_out   = is_active ? bus_s : 1'b1;

   assert_blocked_recessive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_blocked |-> bus_tx);
   assert_inactive_recessive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out != 2'b10) |-> (bus_tx && rxd_out));
endmodule

// File: tb/lin_phy_ctrl_bench.sv
module lin_phy_ctrl_bench;
   localparam int TO = 40;
   localparam int WM = 12;
   localparam int RS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] sys_mode = 2'b00;
   logic stby_ctl = 1'b0, uv_flag = 1'b0, txd_in = 1'b1, bus_in = 1'b1, wake_clr = 1'b0;
   logic bus_tx, rxd_out, tx_blocked, wake_pulse, wake_flag;
   logic [1:0] mode_out;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   lin_phy_ctrl #(.DOM_TIMEOUT(TO), .WAKE_MIN(WM), .RX_SYNC(RS)) u_lin_phy_ctrl (
      .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .stby_ctl(stby_ctl),
      .uv_flag(uv_flag), .txd_in(txd_in), .bus_in(bus_in), .wake_clr(wake_clr),
      .bus_tx(bus_tx), .rxd_out(rxd_out), .mode_out(mode_out),
      .tx_blocked(tx_blocked), .wake_pulse(wake_pulse), .wake_flag(wake_flag)
   );

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input logic [1:0] sm, input logic sb, input logic uv);
      sys_mode = sm; stby_ctl = sb; uv_flag = uv;
      step(1);
   endtask

   task automatic t_reset;
      step(1);
      chk("R8 mode", mode_out, 2'b00);
      chk("R8 bus_tx", {1'b0, bus_tx}, 2'b01);
      chk("R8 rxd", {1'b0, rxd_out}, 2'b01);
      chk("R8 blocked", {1'b0, tx_blocked}, 2'b00);
      chk("R8 wake", {wake_pulse, wake_flag}, 2'b00);
      rst_n = 1'b1;
      step(1);
      chk("R8 mode after release", mode_out, 2'b00);
   endtask

   task automatic t_modes;
      sys_mode = 2'b10; stby_ctl = 1'b0; uv_flag = 1'b0;
      #1 chk("R1 latency", mode_out, 2'b00);
      step(1); chk("R1 active 10", mode_out, 2'b10);
      set_mode(2'b11, 1'b0, 1'b0); chk("R1 active 11", mode_out, 2'b10);
      set_mode(2'b11, 1'b1, 1'b1); chk("R2 lowpwr uv", mode_out, 2'b01);
      set_mode(2'b00, 1'b1, 1'b0); chk("R2 lowpwr 00", mode_out, 2'b01);
      set_mode(2'b01, 1'b0, 1'b0); chk("R3 off 01", mode_out, 2'b00);
      set_mode(2'b10, 1'b0, 1'b1); chk("R3 off uv", mode_out, 2'b00);
   endtask

   task automatic t_rx_tx;
      set_mode(2'b10, 1'b0, 1'b0);
      step(3);
      bus_in = 1'b0;
      step(1); chk("R4 rxd sync not yet", {1'b0, rxd_out}, 2'b01);
      step(1); chk("R4 rxd dominant", {1'b0, rxd_out}, 2'b00);
      bus_in = 1'b1; step(2); chk("R4 rxd recessive", {1'b0, rxd_out}, 2'b01);
      txd_in = 1'b0; #1 chk("R5 tx dominant", {1'b0, bus_tx}, 2'b00);
      step(1); txd_in = 1'b1; #1 chk("R5 tx recessive", {1'b0, bus_tx}, 2'b01);
      set_mode(2'b10, 1'b1, 1'b0);
      bus_in = 1'b0; txd_in = 1'b0; step(3);
      chk("R5 lowpwr tx", {1'b0, bus_tx}, 2'b01);
      chk("R4 lowpwr rxd", {1'b0, rxd_out}, 2'b01);
      txd_in = 1'b1; bus_in = 1'b1;
      set_mode(2'b00, 1'b0, 1'b0);
      txd_in = 1'b0; step(1); chk("R5 off tx", {1'b0, bus_tx}, 2'b01);
      txd_in = 1'b1; step(1);
   endtask

   task automatic t_timeout;
      set_mode(2'b10, 1'b0, 1'b0);
      step(2);
      txd_in = 1'b0;
      step(TO - 1);
      chk("R6 before limit", {tx_blocked, bus_tx}, 2'b00);
      step(1);
      chk("R6 at limit", {tx_blocked, bus_tx}, 2'b11);
      step(6);
      chk("R7 stays blocked", {tx_blocked, bus_tx}, 2'b11);
      txd_in = 1'b1; step(1);
      chk("R7 cleared by high", {tx_blocked, bus_tx}, 2'b01);
      txd_in = 1'b0; #1 chk("R7 rearmed", {1'b0, bus_tx}, 2'b00);
      step(TO - 1);
      chk("R7 count restarted", {tx_blocked, bus_tx}, 2'b00);
      txd_in = 1'b1; step(1);
      txd_in = 1'b0; step(3); txd_in = 1'b1; step(1); txd_in = 1'b0;
      step(TO - 1);
      chk("R6 short low resets count", {tx_blocked, bus_tx}, 2'b00);
      txd_in = 1'b1; step(1);
   endtask

   task automatic t_wake;
      set_mode(2'b00, 1'b1, 1'b0);
      step(3);
      bus_in = 1'b0;
      step(WM + 1); chk("R9 not before min", {wake_pulse, wake_flag}, 2'b00);
      step(1);      chk("R9 pulse at min", {wake_pulse, wake_flag}, 2'b11);
      step(1);      chk("R9 single pulse", {wake_pulse, wake_flag}, 2'b01);
      step(WM + 4); chk("R9 one per period", {wake_pulse, wake_flag}, 2'b01);
      bus_in = 1'b1; step(3);
      chk("R10 sticky", {1'b0, wake_flag}, 2'b01);
      wake_clr = 1'b1; step(1); wake_clr = 1'b0;
      chk("R10 cleared", {1'b0, wake_flag}, 2'b00);
      bus_in = 1'b0; step(WM - 1); bus_in = 1'b1; step(WM + 5);
      chk("R9 short pulse filtered", {wake_pulse, wake_flag}, 2'b00);
      bus_in = 1'b0; step(WM + 1);
      wake_clr = 1'b1; step(1); wake_clr = 1'b0;
      chk("R10 set wins over clear", {wake_pulse, wake_flag}, 2'b11);
      bus_in = 1'b1;
      wake_clr = 1'b1; step(1); wake_clr = 1'b0;
      chk("R10 clear alone", {1'b0, wake_flag}, 2'b00);
   endtask

   task automatic t_no_wake;
      set_mode(2'b01, 1'b0, 1'b0);
      step(2);
      bus_in = 1'b0; step(WM + 6); bus_in = 1'b1;
      chk("R11 off no wake", {wake_pulse, wake_flag}, 2'b00);
      set_mode(2'b10, 1'b0, 1'b0);
      step(2);
      bus_in = 1'b0; step(WM + 6); bus_in = 1'b1;
      chk("R11 active no wake", {wake_pulse, wake_flag}, 2'b00);
      step(3);
   endtask

   initial begin
      t_reset;
      t_modes;
      t_rx_tx;
      t_timeout;
      t_wake;
      t_no_wake;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule